// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block moves bytes from a firmware configuration item store into system memory, driven by a small access descriptor that software places in memory. Software writes a 64-bit pointer to that descriptor into an address register inside a 32-byte register window. Writing the low half of the pointer launches an operation. The engine fetches the 16-byte descriptor over a single-outstanding memory master port and decodes its control word. It can first pick a new configuration item. It then either copies a number of bytes from the item byte stream into memory, or discards that many bytes to move the item's read offset forward. Last, it writes the progress fields and a status word back into the same descriptor.

The item store itself sits outside this block. The engine talks to it through a one-cycle select pulse that carries the item index, and through a valid/ready byte stream. Each accepted stream byte advances the item offset by one. Back-pressure works in both directions. The store may hold `src_valid` low for any number of cycles. The engine raises `src_ready` only when it can take a byte. On the memory side, `mem_req` and its attributes stay constant until `mem_gnt` is seen high at a clock edge. Exactly one response (`mem_rsp_valid`) follows each granted request, after any number of cycles. The engine never has more than one request in flight.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `sel_pulse` and `src_ready` are all low. The stored high pointer half is zero.
- R2: The pointer register is two 32-bit words at window offsets 0x10 (high half) and 0x14 (low half). Reading 0x10 returns 0x51454D55 and reading 0x14 returns 0x20434647 (the 64-bit signature 0x51454D5520434647). Any other offset reads zero.
- R3: Writing offset 0x10 only stores the high half and starts nothing. Writing offset 0x14 starts an operation on the pointer {stored high half, written word}, and `busy` is high in the next cycle.
- R4: When an operation ends, the stored high half returns to zero. A later operation launched by a low-half write alone therefore uses a pointer whose upper 32 bits are zero.
- R5: While `busy` is high, writes to either half are ignored: they neither change the stored high half nor start or queue an operation.
- R6: The descriptor at pointer D is read as four 32-bit big-endian words, in this order: D (control), D+4 (length), D+8 (target high), D+12 (target low). In a word access, `mem_rdata[31:24]`/`mem_wdata[31:24]` is the byte at the lowest address.
- R7: Control word bits: bit 1 read, bit 2 skip, bit 3 select, bits 31:16 item index. Bit 0 on input is ignored. With select set, one `sel_pulse` carrying the index is issued before any byte is taken from the stream.
- R8: With read set, `length` stream bytes are written one at a time (`mem_byte`=1, data in `mem_wdata[7:0]`) to ascending addresses starting at the target.
- R9: With skip set and read clear, `length` stream bytes are accepted and no data write is issued. With both set, read takes precedence. With neither set, no byte moves.
- R10: On completion the engine writes the length word (D+4), the target high word (D+8), the target low word (D+12) and then the control word (D). Length holds the bytes not moved. Target is advanced by the bytes written. The control word is 0 on success.
- R11: An error response to a data write stops the operation. The written-back length and target count only the bytes that were written successfully, and the control word is written as 0x00000001.
- R12: An error response to any descriptor fetch stops the operation at once. No select and no stream byte follow, and only the control word is written, as 0x00000001.
- R13: The memory port holds `mem_req`, address, data and attributes constant until grant, and keeps at most one request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_waddr | input | 5 | Write byte offset within the window |
| reg_wdata | input | 32 | Write data (big-endian word value) |
| reg_raddr | input | 5 | Read byte offset within the window |
| reg_rdata | output | 32 | Read data (combinational) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Request accepted at this edge |
| mem_we | output | 1 | 1 write, 0 read |
| mem_byte | output | 1 | 1 single-byte write, 0 32-bit word access |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read response data |
| sel_pulse | output | 1 | One-cycle item select |
| sel_index | output | 16 | Item index for the select |
| src_valid | input | 1 | Item stream byte available |
| src_ready | output | 1 | Engine accepts a stream byte |
| src_data | input | 8 | Item stream byte |

## Verification
The hardest situation to reach is an error arriving part-way through a copy. Several bytes must have landed, so that the written-back length and target are neither the start values nor the finished ones. The bench reaches it by pointing a five-byte copy two bytes below a memory region that answers every access with an error. It also places a descriptor so that its control and length words are readable but its target words fall in that region, which produces a fetch abort after a valid control word. A pointer write made while a copy is in flight needs a copy long enough to outlast two register writes. Grant and stream stalls stretch every copy so that those writes land while `busy` is high.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PTR_W  = 2 * WORD_W;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned WIN_W  = 5;
  localparam int unsigned WSEL_W = 2;

  localparam logic [PTR_W-1:0] SIGNATURE = 64'h5145_4D55_2043_4647;

  // control word bit positions
  localparam int unsigned CB_RD   = 1;
  localparam int unsigned CB_SKIP = 2;
  localparam int unsigned CB_SEL  = 3;
  localparam int unsigned CB_IDX  = WORD_W - IDX_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FRSP, ST_DECODE, ST_SEL, ST_XFER,
    ST_PULL, ST_WREQ, ST_WRSP, ST_BREQ, ST_BRSP, ST_DONE
  } dma_st_e;

  typedef struct packed {
    logic             rd;
    logic             skip;
    logic             sel;
    logic [IDX_W-1:0] idx;
  } ctl_t;
endpackage

// File: rtl/cfgdma_addr_reg.sv
module cfgdma_addr_reg
  import cfgdma_pkg::*;
#(
  parameter logic [WIN_W-1:0] HI_OFF = 5'h10,
  parameter logic [WIN_W-1:0] LO_OFF = 5'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIN_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WIN_W-1:0]  rd_off,
  input  logic              busy,
  input  logic              clear,
  output logic [WORD_W-1:0] rd_data,
  output logic              start,
  output logic [PTR_W-1:0]  start_ptr
);
  logic [WORD_W-1:0] hi_q;
  logic              wr_ok;

  assign wr_ok = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hi_q <= '0;
    else if (clear)                    hi_q <= '0;
    else if (wr_ok && wr_off == HI_OFF) hi_q <= wr_data;
  end

  // the low half is consumed on the launching write itself
  assign start     = wr_ok && (wr_off == LO_OFF);
  assign start_ptr = {hi_q, wr_data};

  always_comb begin
    if (rd_off == HI_OFF)      rd_data = SIGNATURE[PTR_W-1:WORD_W];
    else if (rd_off == LO_OFF) rd_data = SIGNATURE[WORD_W-1:0];
    else                       rd_data = '0;
  end
endmodule

// File: rtl/cfgdma_desc_regs.sv
module cfgdma_desc_regs
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              adv_len,
  input  logic              adv_tgt,
  input  logic              err_flag,
  output ctl_t              ctl,
  output logic              len_zero,
  output logic [PTR_W-1:0]  tgt,
  output logic [PTR_W-1:0]  desc_addr,
  output logic [WORD_W-1:0] wb_word
);
  logic [PTR_W-1:0]  base_q;
  logic [WORD_W-1:0] len_q;
  logic [PTR_W-1:0]  tgt_q;
  ctl_t              ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      tgt_q  <= '0;
      ctl_q  <= '0;
    end else begin
      if (start) base_q <= start_ptr;
      if (ld_en) begin
        unique case (word_sel)
          2'd0: begin
            ctl_q.rd   <= ld_data[CB_RD];
            ctl_q.skip <= ld_data[CB_SKIP];
            ctl_q.sel  <= ld_data[CB_SEL];
            ctl_q.idx  <= ld_data[WORD_W-1:CB_IDX];
          end
          2'd1: len_q <= ld_data;
          2'd2: tgt_q[PTR_W-1:WORD_W] <= ld_data;
          default: tgt_q[WORD_W-1:0] <= ld_data;
        endcase
      end
      if (adv_len) len_q <= len_q - WORD_W'(1);
      if (adv_tgt) tgt_q <= tgt_q + PTR_W'(1);
    end
  end

  assign ctl       = ctl_q;
  assign len_zero  = (len_q == '0);
  assign tgt       = tgt_q;
  assign desc_addr = base_q + PTR_W'({word_sel, 2'b00});

  always_comb begin
    unique case (word_sel)
      2'd0:    wb_word = {{(WORD_W-1){1'b0}}, err_flag};
      2'd1:    wb_word = len_q;
      2'd2:    wb_word = tgt_q[PTR_W-1:WORD_W];
      default: wb_word = tgt_q[WORD_W-1:0];
    endcase
  end
endmodule

// File: rtl/cfgdma_ctrl.sv
module cfgdma_ctrl
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              c_rd,
  input  logic              c_skip,
  input  logic              c_sel,
  input  logic              len_zero,
  input  logic              mem_gnt,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic              src_valid,
  output logic              busy,
  output logic              clear,
  output logic [WSEL_W-1:0] word_sel,
  output logic              ld_en,
  output logic              adv_len,
  output logic              adv_tgt,
  output logic              cap_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic              sel_pulse,
  output logic              src_ready,
  output logic              err_flag
);
  dma_st_e           st;
  logic [WSEL_W-1:0] wsel;
  logic              err_q;
  logic              moving;
  logic              wr_ok;

  assign moving = c_rd || c_skip;
  assign wr_ok  = (st == ST_WRSP) && rsp_valid && !rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      wsel  <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st    <= ST_FREQ;
          wsel  <= '0;
          err_q <= 1'b0;
        end
        ST_FREQ: if (mem_gnt) st <= ST_FRSP;
        ST_FRSP: if (rsp_valid) begin
          if (rsp_err) begin
            err_q <= 1'b1;
            wsel  <= '0;
            st    <= ST_BREQ;
          end else if (wsel == 2'd3) begin
            st <= ST_DECODE;
          end else begin
            wsel <= wsel + 2'd1;
            st   <= ST_FREQ;
          end
        end
        ST_DECODE: st <= c_sel ? ST_SEL : ST_XFER;
        ST_SEL:    st <= ST_XFER;
        ST_XFER: begin
          if (moving && !len_zero) begin
            st <= ST_PULL;
          end else begin
            wsel <= 2'd1;
            st   <= ST_BREQ;
          end
        end
        ST_PULL: if (src_valid) st <= c_rd ? ST_WREQ : ST_XFER;
        ST_WREQ: if (mem_gnt) st <= ST_WRSP;
        ST_WRSP: if (rsp_valid) begin
          if (rsp_err) begin
            err_q <= 1'b1;
            wsel  <= 2'd1;
            st    <= ST_BREQ;
          end else begin
            st <= ST_XFER;
          end
        end
        ST_BREQ: if (mem_gnt) st <= ST_BRSP;
        ST_BRSP: if (rsp_valid) begin
          if (wsel == 2'd0) st <= ST_DONE;
          else begin
            wsel <= wsel + 2'd1;
            st   <= ST_BREQ;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != ST_IDLE);
    clear     = (st == ST_DONE);
    word_sel  = wsel;
    ld_en     = (st == ST_FRSP) && rsp_valid && !rsp_err;
    cap_en    = (st == ST_PULL) && src_valid;
    adv_tgt   = wr_ok;
    adv_len   = wr_ok || ((st == ST_PULL) && src_valid && !c_rd);
    mem_req   = (st == ST_FREQ) || (st == ST_WREQ) || (st == ST_BREQ);
    mem_we    = (st == ST_WREQ) || (st == ST_BREQ);
    mem_byte  = (st == ST_WREQ);
    sel_pulse = (st == ST_SEL);
    src_ready = (st == ST_PULL);
    err_flag  = err_q;
  end
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter logic [WIN_W-1:0] HI_OFF = 5'h10,
  parameter logic [WIN_W-1:0] LO_OFF = 5'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WIN_W-1:0]  reg_waddr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [WIN_W-1:0]  reg_raddr,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              busy,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              sel_pulse,
  output logic [IDX_W-1:0]  sel_index,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [BYTE_W-1:0] src_data
);
  logic              start, clear, ld_en, adv_len, adv_tgt, cap_en, err_flag, len_zero;
  logic [PTR_W-1:0]  start_ptr, tgt, desc_addr;
  logic [WSEL_W-1:0] word_sel;
  logic [WORD_W-1:0] wb_word;
  logic [BYTE_W-1:0] byte_q;
  ctl_t              ctl;

  cfgdma_addr_reg #(.HI_OFF(HI_OFF), .LO_OFF(LO_OFF)) u_areg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(reg_waddr),
    .wr_data(reg_wdata), .rd_off(reg_raddr), .busy(busy), .clear(clear),
    .rd_data(reg_rdata), .start(start), .start_ptr(start_ptr)
  );

  cfgdma_desc_regs u_desc (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .word_sel(word_sel), .ld_en(ld_en), .ld_data(mem_rdata),
    .adv_len(adv_len), .adv_tgt(adv_tgt), .err_flag(err_flag),
    .ctl(ctl), .len_zero(len_zero), .tgt(tgt), .desc_addr(desc_addr),
    .wb_word(wb_word)
  );

  cfgdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .c_rd(ctl.rd),
    .c_skip(ctl.skip), .c_sel(ctl.sel), .len_zero(len_zero),
    .mem_gnt(mem_gnt), .rsp_valid(mem_rsp_valid), .rsp_err(mem_rsp_err),
    .src_valid(src_valid), .busy(busy), .clear(clear), .word_sel(word_sel),
    .ld_en(ld_en), .adv_len(adv_len), .adv_tgt(adv_tgt), .cap_en(cap_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .sel_pulse(sel_pulse), .src_ready(src_ready), .err_flag(err_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (cap_en) byte_q <= src_data;
  end

  assign sel_index = ctl.idx;
  assign mem_addr  = mem_byte ? tgt : desc_addr;
  assign mem_wdata = mem_byte ? {{(WORD_W-BYTE_W){1'b0}}, byte_q} : wb_word;
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk
  import cfgdma_pkg::*;
#(
  parameter logic [WIN_W-1:0] LO_OFF = 5'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [WIN_W-1:0]  reg_waddr,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_we,
  input logic              mem_byte,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_rsp_valid,
  input logic              sel_pulse,
  input logic              src_ready
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (mem_req && mem_gnt) pend <= 1'b1;
    else if (mem_rsp_valid)      pend <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
      && $stable(mem_we) && $stable(mem_byte)); // R13
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !mem_req); // R13
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_waddr == LO_OFF && !busy |=> busy); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !src_ready && !sel_pulse); // R1
  AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pulse |=> !sel_pulse && !mem_req); // R7
endmodule

bind cfgdma_engine cfgdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
  .busy(busy), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rsp_valid(mem_rsp_valid), .sel_pulse(sel_pulse), .src_ready(src_ready)
);

// File: tb/test_cfgdma_engine.sv
module test_cfgdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [4:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        busy, mem_req, mem_gnt, mem_we, mem_byte;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rdata;
  logic        sel_pulse;
  logic [15:0] sel_index;
  logic        src_valid, src_ready;
  logic [7:0]  src_data;

  always #2 clk = ~clk;

  cfgdma_engine i_cfgdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .busy(busy), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rdata(mem_rdata), .sel_pulse(sel_pulse), .sel_index(sel_index),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data)
  );

  // ---------------- memory and item store model ----------------
  logic [7:0]  mem [0:4095];
  logic [63:0] req_log [0:63];
  logic [31:0] cyc, req_cnt, bw_cnt, hs_cnt, sel_cnt, cur_off;
  logic [15:0] cur_item;
  logic        hw_en = 1'b0;
  logic [11:0] hw_addr = '0;
  logic [7:0]  hw_data = '0;
  logic [11:0] ma;

  function automatic logic [7:0] pat(input logic [15:0] i, input logic [31:0] o);
    return (i[7:0] * 8'd37) + (o[7:0] * 8'd11) + (i[15:8] ^ 8'h5A);
  endfunction

  assign ma       = mem_addr[11:0];
  assign mem_gnt  = (cyc % 3) != 1;
  assign src_valid = (cyc % 5) != 2;
  assign src_data = pat(cur_item, cur_off);

  always @(posedge clk) begin
    if (hw_en) mem[hw_addr] <= hw_data;
    if (!rst_n) begin
      cyc <= 0; req_cnt <= 0; bw_cnt <= 0; hs_cnt <= 0; sel_cnt <= 0;
      cur_off <= 0; cur_item <= 0; mem_rsp_valid <= 0; mem_rsp_err <= 0;
      mem_rdata <= 0;
    end else begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (mem_req && mem_gnt) begin
        req_log[req_cnt[5:0]] <= mem_addr;
        req_cnt <= req_cnt + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_err   <= mem_addr[11];
        if (!mem_we) begin
          mem_rdata <= {mem[ma], mem[ma+12'd1], mem[ma+12'd2], mem[ma+12'd3]};
        end else if (!mem_addr[11]) begin
          if (mem_byte) begin
            mem[ma] <= mem_wdata[7:0];
            bw_cnt  <= bw_cnt + 1;
          end else begin
            mem[ma]       <= mem_wdata[31:24];
            mem[ma+12'd1] <= mem_wdata[23:16];
            mem[ma+12'd2] <= mem_wdata[15:8];
            mem[ma+12'd3] <= mem_wdata[7:0];
          end
        end
      end
      if (sel_pulse) begin
        cur_item <= sel_index;
        cur_off  <= 0;
        sel_cnt  <= sel_cnt + 1;
      end else if (src_valid && src_ready) begin
        cur_off <= cur_off + 1;
        hs_cnt  <= hs_cnt + 1;
      end
    end
  end

  // ---------------- checking infrastructure ----------------
  int vecs = 0;
  int fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [11:0] a);
    return {mem[a], mem[a+12'd1], mem[a+12'd2], mem[a+12'd3]};
  endfunction

  task automatic poke8(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
  endtask

  task automatic poke32(input logic [11:0] a, input logic [31:0] w);
    poke8(a, w[31:24]); poke8(a + 12'd1, w[23:16]);
    poke8(a + 12'd2, w[15:8]); poke8(a + 12'd3, w[7:0]);
  endtask

  task automatic poke_end();
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic reg_write(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk({req, " timeout"}, 64'd1, 64'd0);
  endtask

  task automatic setup_desc(input logic [11:0] b, input logic [31:0] c,
                            input logic [31:0] l, input logic [63:0] t);
    poke32(b, c); poke32(b + 12'd4, l);
    poke32(b + 12'd8, t[63:32]); poke32(b + 12'd12, t[31:0]);
  endtask

  task automatic reg_read(input logic [4:0] off, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_raddr = off;
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  // ---------------- stimulus ----------------
  logic [15:0] exp_item = 0;
  logic [31:0] exp_off = 0;

  initial begin
    logic [31:0] r0, b0, h0, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 mem_req", 64'(mem_req), 64'd0);
    chk("R1 src_ready", 64'(src_ready), 64'd0);
    chk("R1 sel_pulse", 64'(sel_pulse), 64'd0);

    reg_read(5'h10, 32'h5145_4D55, "R2 sig hi");
    reg_read(5'h14, 32'h2043_4647, "R2 sig lo");
    reg_read(5'h08, 32'h0, "R2 other");
    reg_read(5'h18, 32'h0, "R2 other");

    // ---- sweep over modes and lengths (R6..R10) ----
    for (int m = 0; m < 7; m++) begin
      for (int len = 0; len < 5; len++) begin
        int op;
        logic rd, sk, sl;
        logic [15:0] idx;
        logic [31:0] ctlw;
        logic [11:0] base, tg;
        int moved, wrote;
        op  = m * 5 + len;
        rd  = (m == 0) || (m == 2) || (m == 6);
        sk  = (m == 1) || (m == 3) || (m == 6);
        sl  = (m == 2) || (m == 3) || (m == 5);
        idx = 16'(m * 4099 + len * 257 + 1);
        ctlw = {idx, 12'h000, sl, sk, rd, 1'(op % 2)};
        base = 12'h040;
        tg   = 12'(12'h200 + op * 8);
        setup_desc(base, ctlw, len, {32'h0, 20'h0, tg});
        for (int k = 0; k <= len; k++) poke8(tg + 12'(k), 8'hEE);
        poke_end();
        r0 = req_cnt; b0 = bw_cnt; h0 = hs_cnt; s0 = sel_cnt;
        reg_write(5'h14, {20'h0, base});
        wait_idle("R10");
        if (sl) begin exp_item = idx; exp_off = 0; end
        moved = (rd || sk) ? len : 0;
        wrote = rd ? len : 0;
        for (int k = 0; k < 4; k++)
          chk("R6 fetch order", req_log[6'(r0 + k)], 64'(base + 12'(4 * k)));
        chk("R7 select count", 64'(sel_cnt - s0), 64'(sl));
        chk("R9 stream bytes", 64'(hs_cnt - h0), 64'(moved));
        chk("R9 byte writes", 64'(bw_cnt - b0), 64'(wrote));
        for (int k = 0; k < len; k++)
          chk("R8 data", 64'(mem[tg + 12'(k)]),
              rd ? 64'(pat(exp_item, exp_off + 32'(k))) : 64'hEE);
        chk("R8 no overrun", 64'(mem[tg + 12'(len)]), 64'hEE);
        chk("R10 status", 64'(rd32(base)), 64'd0);
        chk("R10 length", 64'(rd32(base + 12'd4)), 64'(len - moved));
        chk("R10 target", {rd32(base + 12'd8), rd32(base + 12'd12)}, 64'(tg) + 64'(wrote));
        chk("R10 wb order len", req_log[6'(r0 + 4 + wrote)], 64'(base + 12'd4));
        chk("R10 wb order ctl", req_log[6'(r0 + 7 + wrote)], 64'(base));
        exp_off = exp_off + 32'(moved);
      end
    end

    // ---- R3: high half alone starts nothing; 64-bit pointer ----
    r0 = req_cnt;
    reg_write(5'h10, 32'h0000_0001);
    repeat (4) @(negedge clk);
    chk("R3 high write idle", 64'(busy), 64'd0);
    chk("R3 high write no req", 64'(req_cnt - r0), 64'd0);
    setup_desc(12'h100, {16'h0777, 12'h0, 4'b1010}, 32'd2, 64'h500);
    poke_end();
    r0 = req_cnt;
    reg_write(5'h14, 32'h0000_0100);
    chk("R3 busy after launch", 64'(busy), 64'd1);
    wait_idle("R3");
    chk("R3 64-bit pointer", req_log[6'(r0)], 64'h0000_0001_0000_0100);
    chk("R8 64-bit op data", 64'(mem[12'h501]), 64'(pat(16'h0777, 1)));

    // ---- R4: high half cleared after the operation ----
    setup_desc(12'h140, 32'h0, 32'd0, 64'h0);
    poke_end();
    r0 = req_cnt;
    reg_write(5'h14, 32'h0000_0140);
    wait_idle("R4");
    chk("R4 high half cleared", req_log[6'(r0)], 64'h140);

    // ---- R5: writes while busy ignored ----
    setup_desc(12'h0E0, {16'h0123, 12'h0, 4'b1010}, 32'd4, 64'h400);
    setup_desc(12'h0F0, 32'h0, 32'd0, 64'h0);
    poke_end();
    r0 = req_cnt;
    reg_write(5'h14, 32'h0000_00E0);
    reg_write(5'h10, 32'h0000_0005);
    reg_write(5'h14, 32'h0000_00F0);
    chk("R5 still busy", 64'(busy), 64'd1);
    wait_idle("R5");
    repeat (6) @(negedge clk);
    chk("R5 no queued launch", 64'(busy), 64'd0);
    chk("R5 request total", 64'(req_cnt - r0), 64'd12);
    r0 = req_cnt;
    reg_write(5'h14, 32'h0000_00F0);
    wait_idle("R5");
    chk("R5 high write ignored", req_log[6'(r0)], 64'h0F0);

    // ---- R11: data write error part-way ----
    setup_desc(12'h0C0, {16'h0055, 12'h0, 4'b1010}, 32'd5, 64'h7FE);
    poke_end();
    reg_write(5'h14, 32'h0000_00C0);
    wait_idle("R11");
    chk("R11 status", 64'(rd32(12'h0C0)), 64'd1);
    chk("R11 length left", 64'(rd32(12'h0C4)), 64'd3);
    chk("R11 target reached", {rd32(12'h0C8), rd32(12'h0CC)}, 64'h800);
    chk("R11 bytes kept", 64'(mem[12'h7FF]), 64'(pat(16'h0055, 1)));

    // ---- R12: descriptor fetch error ----
    setup_desc(12'h7F8, {16'h0099, 12'h0, 4'b1010}, 32'd3, 64'h600);
    poke_end();
    h0 = hs_cnt; s0 = sel_cnt; b0 = bw_cnt;
    reg_write(5'h14, 32'h0000_07F8);
    wait_idle("R12");
    chk("R12 status", 64'(rd32(12'h7F8)), 64'd1);
    chk("R12 length untouched", 64'(rd32(12'h7FC)), 64'd3);
    chk("R12 no select", 64'(sel_cnt - s0), 64'd0);
    chk("R12 no stream", 64'(hs_cnt - h0), 64'd0);
    chk("R12 no data write", 64'(bw_cnt - b0), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule